// File: doc/BRIEF.md
# Shared-Bus Finite-Difference Polynomial Engine

This block produces successive values of a polynomial of fixed order (four by default) by repeated addition of forward differences. It holds five difference registers: F, G, H, I and J. F always holds the current polynomial value and J holds the constant top-order difference. One operand register A, one result register C and a single adder complete the datapath. Every transfer between these registers goes over one shared 32-bit bus.

A Mealy controller sequences the updates. It uses three states per difference stage, twelve states in all at the default order. In each state one register drives the bus and one register captures a value. As a result, a fresh polynomial value appears once every twelve enabled clocks, not once per clock.

In use, software-free logic loads the initial differences in one cycle while the engine is stopped. It then raises the run enable. Each new value of F is announced by a one-clock strobe. All arithmetic wraps modulo 2^32.

Top module: `diffeng_top`

## Requirements
- R1: While the active-low reset is asserted, `value_o` reads 0 and `value_vld_o` reads 0. The sequence then starts from its first state.
- R2: When `load_i` is high and `run_i` is low at a clock edge, the five registers take their values from `coef_i`. The mapping is F from bits [31:0], G from [63:32], H from [95:64], I from [127:96] and J from [159:128]. `value_o` shows the new F after that edge, and the sequence restarts at its first state.
- R3: A `load_i` pulse while `run_i` is high has no effect. The values and strobe timing continue exactly as if no pulse had come.
- R4: Each clock edge with `run_i` high performs one transfer. Per stage k (F=0 … I=3) the order is A←reg[k], then C←A+reg[k+1], then reg[k]←C, for stages F, G, H, I in turn, and then back to F. F therefore changes on the 3rd enabled edge after a restart and every 12 enabled edges after that.
- R5: In every enabled state exactly one source drives the bus. When `run_i` is low, no source drives it.
- R6: The adder always sums A and the bus. Only C captures the sum, and C changes only in the add states.
- R7: After loading the forward differences of p at x=0, the successive F values are p(0), p(1), p(2), … modulo 2^32.
- R8: J is never altered by running. It changes only through a load.
- R9: `value_vld_o` is high for exactly one clock, in the cycle in which a newly computed F first appears on `value_o`. At no other time does it go high.
- R10: While `run_i` is low, all registers and the sequence position hold, and `value_vld_o` stays low. When `run_i` returns high, the sequence continues from where it paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously by the surrounding logic |
| load_i | input | 1 | Load strobe for the initial differences, honoured only while `run_i` is low |
| coef_i | input | 160 | Initial differences, F in the lowest 32 bits up to J in the highest |
| run_i | input | 1 | Run enable: one transfer per clock while high |
| value_o | output | 32 | Current polynomial value (register F) |
| value_vld_o | output | 1 | One-clock strobe marking a new value on `value_o` |

## Verification
The bench loads difference tables computed from polynomials it evaluates directly by Horner's rule, including one with large coefficients so that every difference wraps. It then compares each strobe and each F value against the expected enabled-cycle count. A controller that ran a stage out of order, or that wrote J, would produce values off the polynomial. An off-by-one in the state count would move the strobe away from the 3rd and every 12th enabled cycle.

The bench pauses the engine mid-stage. A design that kept stepping, or lost its position while paused, would shift every later strobe. The bench also pulses the load during a run. A design that accepted it would jump to the junk table.

Finally, the bench reloads a fresh table partway through a pass. A design that did not restart at the first state would strobe at the wrong cycle after the reload.

// File: rtl/diffeng_pkg.sv
package diffeng_pkg;

  // Three transfer phases performed for every difference stage.
  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,  // A takes the lower difference register
    PH_ADD   = 2'd1,  // C takes A plus the next-higher register
    PH_WB    = 2'd2   // the lower register takes C back
  } phase_e;

  // Width of the stage counter for a given polynomial order.
  function automatic int unsigned stage_w(int unsigned order);
    return (order < 2) ? 1 : $clog2(order);
  endfunction

endpackage

// File: rtl/diffeng_ctrl.sv
module diffeng_ctrl
  import diffeng_pkg::*;
#(
  parameter int ORDER = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             restart_i,
  output logic [ORDER+1:0] src_sel_o,   // bit ORDER+1 selects C
  output logic             a_en_o,
  output logic             c_en_o,
  output logic [ORDER:0]   reg_we_o
);

  localparam int NREG = ORDER + 1;
  localparam int SW   = stage_w(ORDER);
  localparam logic [SW-1:0] LAST_STAGE = SW'(ORDER - 1);

  logic [SW-1:0] stage_q, stage_d;
  phase_e        phase_q, phase_d;
  logic          step_en;
  logic [SW:0]   stage_ext, stage_nxt;

  // Next-state logic
  always_comb begin
    stage_d = stage_q;
    phase_d = phase_q;
    if (restart_i) begin
      stage_d = '0;
      phase_d = PH_FETCH;
    end else if (run_i) begin
      unique case (phase_q)
        PH_FETCH: phase_d = PH_ADD;
        PH_ADD:   phase_d = PH_WB;
        default: begin
          phase_d = PH_FETCH;
          stage_d = (stage_q == LAST_STAGE) ? '0 : stage_q + 1'b1;
        end
      endcase
    end
  end

  assign step_en = restart_i | run_i;

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      phase_q <= PH_FETCH;
    end else if (step_en) begin
      stage_q <= stage_d;
      phase_q <= phase_d;
    end
  end

  // Mealy outputs: every control is gated by the run enable.
  assign stage_ext = {1'b0, stage_q};
  assign stage_nxt = stage_ext + (SW+1)'(1);

  assign a_en_o = run_i & (phase_q == PH_FETCH);
  assign c_en_o = run_i & (phase_q == PH_ADD);
  assign src_sel_o[NREG] = run_i & (phase_q == PH_WB);

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign src_sel_o[g] = run_i &
      (((phase_q == PH_FETCH) && (stage_ext == (SW+1)'(g))) ||
       ((phase_q == PH_ADD)   && (stage_nxt == (SW+1)'(g))));
    if (g < ORDER) begin : g_wr
      assign reg_we_o[g] = run_i & (phase_q == PH_WB) & (stage_ext == (SW+1)'(g));
    end else begin : g_top
      assign reg_we_o[g] = 1'b0;   // highest difference is constant
    end
  end

endmodule

// File: rtl/diffeng_regbank.sv
module diffeng_regbank #(
  parameter int DW   = 32,
  parameter int NREG = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [NREG*DW-1:0] coef_i,
  input  logic [NREG-1:0]    we_i,
  input  logic [DW-1:0]      bus_i,
  output logic [NREG*DW-1:0] regs_o
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] q;
    logic [DW-1:0] d;
    logic          en;

    assign en = load_i | we_i[g];
    assign d  = load_i ? coef_i[g*DW +: DW] : bus_i;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= d;
      end
    end

    assign regs_o[g*DW +: DW] = q;
  end

endmodule

// File: rtl/diffeng_bus.sv
module diffeng_bus #(
  parameter int DW   = 32,
  parameter int NSRC = 6
) (
  input  logic [NSRC-1:0]    sel_i,
  input  logic [NSRC*DW-1:0] src_i,
  output logic [DW-1:0]      bus_o
);

  // AND-OR bus: one-hot select, zero when idle.
  always_comb begin
    bus_o = '0;
    for (int s = 0; s < NSRC; s++) begin
      bus_o = bus_o | (src_i[s*DW +: DW] & {DW{sel_i[s]}});
    end
  end

endmodule

// File: rtl/diffeng_accum.sv
module diffeng_accum #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_en_i,
  input  logic          c_en_i,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] c_o
);

  logic [DW-1:0] a_q, c_q, sum;

  assign sum = a_q + bus_i;   // wraps modulo 2^DW

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
    end else if (a_en_i) begin
      a_q <= bus_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q <= '0;
    end else if (c_en_i) begin
      c_q <= sum;
    end
  end

  assign a_o = a_q;
  assign c_o = c_q;

endmodule

// File: rtl/diffeng_top.sv
module diffeng_top #(
  parameter int DW    = 32,
  parameter int ORDER = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic [(ORDER+1)*DW-1:0] coef_i,
  input  logic                    run_i,
  output logic [DW-1:0]           value_o,
  output logic                    value_vld_o
);

  localparam int NREG = ORDER + 1;
  localparam int NSRC = NREG + 1;

  logic               restart;
  logic [NSRC-1:0]    src_sel;
  logic               a_en, c_en;
  logic [NREG-1:0]    reg_we;
  logic [NREG*DW-1:0] regs;
  logic [DW-1:0]      bus, a_q, c_q, j_q;
  logic               vld_q;

  assign restart = load_i & ~run_i;

  diffeng_ctrl #(.ORDER(ORDER)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run_i),
    .restart_i (restart),
    .src_sel_o (src_sel),
    .a_en_o    (a_en),
    .c_en_o    (c_en),
    .reg_we_o  (reg_we)
  );

  diffeng_regbank #(.DW(DW), .NREG(NREG)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (restart),
    .coef_i (coef_i),
    .we_i   (reg_we),
    .bus_i  (bus),
    .regs_o (regs)
  );

  diffeng_bus #(.DW(DW), .NSRC(NSRC)) u_bus (
    .sel_i (src_sel),
    .src_i ({c_q, regs}),
    .bus_o (bus)
  );

  diffeng_accum #(.DW(DW)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_en_i (a_en),
    .c_en_i (c_en),
    .bus_i  (bus),
    .a_o    (a_q),
    .c_o    (c_q)
  );

  // Strobe follows the write-back into F by one register stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= reg_we[0];
    end
  end

  assign value_o     = regs[DW-1:0];
  assign j_q         = regs[ORDER*DW +: DW];
  assign value_vld_o = vld_q;

endmodule

// File: rtl/diffeng_chk.sv
module diffeng_chk #(
  parameter int DW    = 32,
  parameter int ORDER = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    load_i,
  input logic                    run_i,
  input logic [(ORDER+1)*DW-1:0] coef_i,
  input logic [DW-1:0]           value_o,
  input logic                    value_vld_o,
  input logic [ORDER+1:0]        src_sel,
  input logic [DW-1:0]           a_q,
  input logic [DW-1:0]           c_q,
  input logic [DW-1:0]           bus,
  input logic                    c_en,
  input logic [DW-1:0]           j_q
);

  assert_one_driver_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_sel) && (run_i == (src_sel != '0)));

  assert_sum_to_c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    c_en |=> (c_q == $past(a_q) + $past(bus)));

  assert_c_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !c_en |=> $stable(c_q));

  assert_j_const_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_i && !run_i) |=> $stable(j_q));

  assert_load_f_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !run_i) |=> (value_o == $past(coef_i[DW-1:0])));

  assert_strobe_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    value_vld_o |=> !value_vld_o);

  assert_change_marked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(value_o) |-> (value_vld_o || $past(load_i && !run_i)));

  assert_pause_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !load_i) |=> ($stable(value_o) && !value_vld_o));

endmodule

bind diffeng_top diffeng_chk #(.DW(DW), .ORDER(ORDER)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_i      (load_i),
  .run_i       (run_i),
  .coef_i      (coef_i),
  .value_o     (value_o),
  .value_vld_o (value_vld_o),
  .src_sel     (src_sel),
  .a_q         (a_q),
  .c_q         (c_q),
  .bus         (bus),
  .c_en        (c_en),
  .j_q         (j_q)
);

// File: tb/sim_diffeng_top.sv
`timescale 1ns/1ps
module sim_diffeng_top;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         load_i;
  logic [159:0] coef_i;
  logic         run_i;
  logic [31:0]  value_o;
  logic         value_vld_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [31:0] pa [5];   // polynomial coefficients, pa[0] constant term

  always #10 clk = ~clk;   // 50 MHz

  diffeng_top u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .coef_i      (coef_i),
    .run_i       (run_i),
    .value_o     (value_o),
    .value_vld_o (value_vld_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pval(input int x);
    logic [31:0] acc;
    acc = pa[4];
    for (int i = 3; i >= 0; i--) acc = acc * 32'(x) + pa[i];
    return acc;
  endfunction

  // Forward differences of p at x = 0, F in the lowest word.
  function automatic logic [159:0] diff_table();
    logic [31:0]  t [5];
    logic [159:0] r;
    for (int i = 0; i < 5; i++) t[i] = pval(i);
    r[31:0] = t[0];
    for (int lvl = 1; lvl < 5; lvl++) begin
      for (int i = 0; i <= 4 - lvl; i++) t[i] = t[i+1] - t[i];
      r[lvl*32 +: 32] = t[0];
    end
    return r;
  endfunction

  task automatic set_poly(input logic [31:0] c0, c1, c2, c3, c4);
    pa[0] = c0; pa[1] = c1; pa[2] = c2; pa[3] = c3; pa[4] = c4;
  endtask

  task automatic do_load();
    @(negedge clk);
    run_i  = 1'b0;
    load_i = 1'b1;
    coef_i = diff_table();
    @(negedge clk);
    load_i = 1'b0;
    chk(value_o == pval(0), "R2 load shows p(0)", value_o, pval(0));
    chk(value_vld_o == 1'b0, "R2 no strobe on load", 32'(value_vld_o), 32'd0);
  endtask

  // Runs n_active enabled cycles with optional pause and stray load.
  task automatic run_seq(input int n_active, input int pause_at, input int pause_len, input int junk_at);
    int act = 0;
    int k   = 0;
    int pc  = 0;
    while (act < n_active) begin
      bit paused;
      bit exp_vld;
      paused = (pause_len > 0) && (act == pause_at) && (pc < pause_len);
      run_i  = !paused;
      if (!paused && act == junk_at) begin
        load_i = 1'b1;
        coef_i = {5{32'hDEAD_BEEF}};
      end
      @(negedge clk);
      load_i = 1'b0;
      if (paused) begin
        pc++;
        exp_vld = 1'b0;
        chk(value_vld_o == 1'b0, "R10 no strobe while paused", 32'(value_vld_o), 32'd0);
        chk(value_o == pval(k), "R10 value held while paused", value_o, pval(k));
      end else begin
        act++;
        exp_vld = (act % 12) == 3;
        chk(value_vld_o == exp_vld, "R4 R9 strobe timing", 32'(value_vld_o), 32'(exp_vld));
        if (exp_vld) k++;
        // R5 R6 R7 R8: a wrong driver, sum or J write breaks the value
        chk(value_o == pval(k), "R7 polynomial value", value_o, pval(k));
      end
    end
    run_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_n  = 1'b0;
    load_i = 1'b0;
    run_i  = 1'b0;
    coef_i = '0;
    repeat (3) @(negedge clk);
    chk(value_o == 32'd0, "R1 reset value", value_o, 32'd0);
    chk(value_vld_o == 1'b0, "R1 reset strobe", 32'(value_vld_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(value_o == 32'd0, "R1 value after release", value_o, 32'd0);
  endtask

  task automatic t_basic();
    set_poly(32'd7, 32'd3, 32'd2, 32'd1, 32'd1);
    do_load();
    run_seq(12*6, -1, 0, -1);
  endtask

  task automatic t_wrap();
    set_poly(32'hFFFF_FFF0, 32'h8000_0001, 32'hFFFF_FFFD, 32'h1234_5679, 32'hF000_0003);
    do_load();
    run_seq(12*8, -1, 0, -1);
  endtask

  task automatic t_pause();
    set_poly(32'd100, 32'hFFFF_FFFF, 32'd5, 32'd0, 32'd2);
    do_load();
    run_seq(12*4, 5, 7, -1);
    do_load();
    run_seq(12*3, 14, 3, -1);
  endtask

  task automatic t_stray_load();
    set_poly(32'd1, 32'd1, 32'd1, 32'd1, 32'd1);
    do_load();
    run_seq(12*4, -1, 0, 7);   // R3 stray load ignored
  endtask

  task automatic t_reload_mid();
    set_poly(32'd9, 32'd4, 32'd0, 32'd3, 32'd0);
    do_load();
    run_seq(20, -1, 0, -1);
    set_poly(32'd2, 32'd6, 32'd1, 32'd0, 32'd4);
    do_load();                 // R2 restart at first state
    run_seq(12*3, -1, 0, -1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R4 watchdog actual=%0d expected=%0d", 150000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_wrap();
    t_pause();
    t_stray_load();
    t_reload_mid();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule